// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a single column command into the stream of column addresses that a synchronous DRAM burst walks through. On a start pulse it takes a starting column, a 3-bit burst length code and an ordering bit, and from the next clock on it presents one column address per cycle. Each address comes with a valid flag, and with a last flag on the closing beat of a bounded burst.

Bounded bursts of 1, 2, 4 or 8 beats stay inside the aligned group of that many columns. The column bits above the group never change, and only the low bits wrap, either counting up or as the start XORed with the beat count. A full-page mode counts up through the whole page and wraps around. It never ends by itself, so it runs until a stop pulse or a new start. A start may arrive on any clock. It discards whatever is left of the current burst and begins a full-length burst from the new column. The page width is a parameter.

The control is a three-state machine. ST_IDLE produces no beats. ST_BURST steps through a bounded burst. ST_PAGE steps through a page without end. The transitions are:
- Any state goes to ST_BURST or ST_PAGE on start. Start wins over stop.
- ST_BURST goes to ST_IDLE on stop, or after its final beat.
- ST_BURST stays in ST_BURST while beats remain.
- ST_PAGE goes to ST_IDLE on stop, and otherwise stays in ST_PAGE.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and in ST_IDLE, col_valid_o and col_last_o are 0.
- R2: A start sampled on a clock edge puts col_valid_o=1 and col_o=start_col_i on the outputs right after that edge, whatever the state was.
- R3: len_code_i is decoded as follows: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page. The codes 3'b100, 3'b101 and 3'b110 are reserved and give a single beat.
- R4: In a bounded burst of length L, the column bits at and above log2(L) hold their start value on every beat.
- R5: With order_il_i=0 the low bits of beat i are (start+i) mod L. With order_il_i=1 they are start XOR i. For example, length 8 from column 2 gives 2,3,0,1,6,7,4,5.
- R6: Full page with order_il_i=0 gives start+i modulo 2**COL_W on beat i. It wraps past the top column, continues until stop or start, and never raises col_last_o.
- R7: col_last_o is 1 exactly on the final beat of a bounded burst. col_valid_o is 0 on the cycle after it, unless a new start was sampled.
- R8: A stop sampled without start makes col_valid_o 0 after that edge. A stop in ST_IDLE has no effect.
- R9: A start during an active burst drops its remaining beats and begins a full-length burst from the new column.
- R10: Full-page code with order_il_i=1 is invalid and yields a single beat with col_last_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a new burst this cycle |
| start_col_i | input | COL_W | Starting column address |
| len_code_i | input | 3 | Burst length code (see R3) |
| order_il_i | input | 1 | 0 = sequential, 1 = interleaved order |
| stop_i | input | 1 | End the current burst |
| col_o | output | COL_W | Column address of the current beat |
| col_valid_o | output | 1 | col_o holds a beat |
| col_last_o | output | 1 | Final beat of a bounded burst |

## Verification
Both orderings run for every bounded length, with start columns in the middle of an aligned group, so that a wrap that leaks into the upper bits shows up in the address. The interleaved length-8 burst from column 2 is compared against the listed order, because a plain XOR and a plain increment give different sequences from that column. A full-page run crosses the top column to confirm the wrap around the page and the absence of any last flag. Interrupts are exercised by a start in the middle of a burst, by start and stop together, and by a stop in idle. Reserved codes and the invalid full-page-interleaved combination are checked to produce exactly one beat.

// File: rtl/bcag_pkg.sv
package bcag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } bcag_state_e;

    localparam logic [2:0] LEN_1    = 3'b000;
    localparam logic [2:0] LEN_2    = 3'b001;
    localparam logic [2:0] LEN_4    = 3'b010;
    localparam logic [2:0] LEN_8    = 3'b011;
    localparam logic [2:0] LEN_PAGE = 3'b111;

endpackage

// File: rtl/bcag_len_decode.sv
module bcag_len_decode
    import bcag_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [2:0]       len_code,
    input  logic             order_il,
    output logic [COL_W-1:0] wrap_mask,
    output logic             page_mode
);

    localparam logic [COL_W-1:0] ALL_ONES = '1;

    always_comb begin
        wrap_mask = '0;
        page_mode = 1'b0;
        unique case (len_code)
            LEN_1: wrap_mask = COL_W'(0);
            LEN_2: wrap_mask = COL_W'(1);
            LEN_4: wrap_mask = COL_W'(3);
            LEN_8: wrap_mask = COL_W'(7);
            LEN_PAGE: begin
                if (!order_il) begin
                    wrap_mask = ALL_ONES;
                    page_mode = 1'b1;
                end else begin
                    // invalid pairing: single beat
                    wrap_mask = '0;
                end
            end
            default: wrap_mask = '0; // reserved codes: single beat
        endcase
    end

endmodule

// File: rtl/bcag_addr_gen.sv
module bcag_addr_gen #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] mask,
    input  logic [COL_W-1:0] beat,
    input  logic             order_il,
    output logic [COL_W-1:0] addr
);

    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] il_low;
    logic [COL_W-1:0] low;

    assign seq_low = base + beat;
    assign il_low  = base ^ beat;
    assign low     = order_il ? il_low : seq_low;

    // per-bit merge: wrapping bits from the stepped value, others from base
    for (genvar b = 0; b < COL_W; b++) begin : g_merge
        assign addr[b] = mask[b] ? low[b] : base[b];
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcag_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             order_il_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             col_valid_o,
    output logic             col_last_o
);

    localparam int BEAT_W = COL_W;

    bcag_state_e      state_q, state_d;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             order_q;
    logic [BEAT_W-1:0] beat_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             advance;
    logic [COL_W-1:0] gen_base;
    logic [COL_W-1:0] gen_mask;
    logic [BEAT_W-1:0] gen_beat;
    logic             gen_order;
    logic [COL_W-1:0] gen_addr;

    bcag_len_decode #(.COL_W(COL_W)) u_dec (
        .len_code  (len_code_i),
        .order_il  (order_il_i),
        .wrap_mask (dec_mask),
        .page_mode (dec_page)
    );

    always_comb begin
        advance = 1'b0;
        if (!start_i && !stop_i) begin
            unique case (state_q)
                ST_BURST: advance = (beat_q != mask_q);
                ST_PAGE:  advance = 1'b1;
                default:  advance = 1'b0;
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = dec_page ? ST_PAGE : ST_BURST;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BURST: state_d = advance ? ST_BURST : ST_IDLE;
                ST_PAGE:  state_d = stop_i ? ST_IDLE : ST_PAGE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    assign gen_base  = start_i ? start_col_i : base_q;
    assign gen_mask  = start_i ? dec_mask : mask_q;
    assign gen_order = start_i ? order_il_i : order_q;
    assign gen_beat  = start_i ? '0 : beat_q + BEAT_W'(1);

    bcag_addr_gen #(.COL_W(COL_W)) u_gen (
        .base     (gen_base),
        .mask     (gen_mask),
        .beat     (gen_beat),
        .order_il (gen_order),
        .addr     (gen_addr)
    );

    // state register and burst context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            mask_q  <= '0;
            order_q <= 1'b0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                base_q  <= start_col_i;
                mask_q  <= dec_mask;
                order_q <= order_il_i;
                beat_q  <= '0;
            end else if (advance) begin
                beat_q  <= gen_beat;
            end
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_o       <= '0;
            col_valid_o <= 1'b0;
            col_last_o  <= 1'b0;
        end else begin
            col_valid_o <= (state_d != ST_IDLE);
            col_o       <= (state_d != ST_IDLE) ? gen_addr : col_o;
            col_last_o  <= (state_d == ST_BURST) && (gen_beat == gen_mask);
        end
    end

    // R1: idle means no beat
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!col_valid_o && !col_last_o));

    // R2: first beat is the start column
    assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (col_valid_o && col_o == $past(start_col_i)));

    // R4: bits above the wrap group hold
    assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && $past(col_valid_o) && !$past(start_i))
        |-> ((col_o & ~mask_q) == ($past(col_o) & ~mask_q)));

    // R6: no last flag in page mode
    assert_page_no_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE) |-> !col_last_o);

    // R7: last ends the burst
    assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last_o && !start_i) |=> !col_valid_o);

    // R8: stop without start ends output
    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !col_valid_o);

endmodule

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;

    localparam int COL_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             order_il_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             col_valid_o;
    logic             col_last_o;

    always #4 clk = ~clk; // 125 MHz

    burst_col_gen #(.COL_W(COL_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .len_code_i  (len_code_i),
        .order_il_i  (order_il_i),
        .stop_i      (stop_i),
        .col_o       (col_o),
        .col_valid_o (col_valid_o),
        .col_last_o  (col_last_o)
    );

    typedef struct {
        int               cyc;
        logic             v;
        logic [COL_W-1:0] a;
        logic             l;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (col_valid_o !== e.v || (e.v && (col_o !== e.a || col_last_o !== e.l))
                || (!e.v && col_last_o !== 1'b0)) begin
                failures++;
                $display("FAIL %s: got valid=%0b addr=%0d last=%0b expected valid=%0b addr=%0d last=%0b",
                         e.tag, col_valid_o, col_o, col_last_o, e.v, e.a, e.l);
            end
        end
    end

    // driver: apply one cycle of inputs, push the expected output after the next edge
    task automatic step(input logic s, input logic [COL_W-1:0] col, input logic [2:0] code,
                        input logic typ, input logic stp,
                        input logic ev, input logic [COL_W-1:0] ea, input logic el,
                        input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        start_i = s; start_col_i = col; len_code_i = code; order_il_i = typ; stop_i = stp;
        e.cyc = cyc + 1; e.v = ev; e.a = ea; e.l = el; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // expected address of beat i; len 0 means full page
    function automatic logic [COL_W-1:0] model(input logic [COL_W-1:0] col, input int len,
                                               input logic typ, input int i);
        logic [COL_W-1:0] m;
        logic [COL_W-1:0] iv;
        m  = (len == 0) ? '1 : COL_W'(len - 1);
        iv = COL_W'(i);
        if (typ) return (col & ~m) | ((col ^ iv) & m);
        return (col & ~m) | ((col + iv) & m);
    endfunction

    // issue a start and observe `beats` beats
    task automatic go(input logic [COL_W-1:0] col, input logic [2:0] code, input logic typ,
                      input int len, input int beats, input string tag);
        for (int i = 0; i < beats; i++) begin
            step(i == 0, col, code, typ, 1'b0, 1'b1, model(col, len, typ, i),
                 (len != 0) && (i == len - 1), tag);
        end
    endtask

    task automatic idle(input string tag);
        step(1'b0, '0, 3'b000, 1'b0, 1'b0, 1'b0, '0, 1'b0, tag);
    endtask

    initial begin
        int wd;
        wd = 0;
        fork
            begin
                repeat (3) @(posedge clk);
                #1 rst_n = 1'b1;
                @(negedge clk);
                checks++;
                if (col_valid_o !== 1'b0 || col_last_o !== 1'b0) begin
                    failures++;
                    $display("FAIL R1 reset: got valid=%0b last=%0b expected valid=0 last=0",
                             col_valid_o, col_last_o);
                end
                idle("R1 idle");

                // R4 R5 sequential length 8 mid-group, R7 last
                go(9'd29, 3'b011, 1'b0, 8, 8, "R4 R5 R7 seq8");
                idle("R7 end after last");
                // R5 interleaved example: 2,3,0,1,6,7,4,5 in group at 64
                begin
                    int il[8] = '{2, 3, 0, 1, 6, 7, 4, 5};
                    for (int i = 0; i < 8; i++)
                        step(i == 0, 9'd66, 3'b011, 1'b1, 1'b0, 1'b1,
                             COL_W'(64 + il[i]), i == 7, "R5 il8 list");
                end
                idle("R5 end");
                // R3 lengths 1,2,4 both orders
                go(9'd100, 3'b000, 1'b0, 1, 1, "R3 len1");
                idle("R3 len1 end");
                go(9'd101, 3'b001, 1'b0, 2, 2, "R3 len2 seq");
                go(9'd101, 3'b001, 1'b1, 2, 2, "R3 len2 il");
                go(9'd143, 3'b010, 1'b0, 4, 4, "R3 R4 len4 seq");
                go(9'd141, 3'b010, 1'b1, 4, 4, "R3 R5 len4 il");
                idle("R3 len4 end");
                // R6 full page across top, then stop (R8)
                go(9'd500, 3'b111, 1'b0, 0, 40, "R6 page");
                step(1'b0, '0, 3'b000, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R8 stop page");
                idle("R8 after stop");
                // R8 stop mid bounded burst
                go(9'd200, 3'b011, 1'b0, 8, 3, "R8 pre");
                step(1'b0, '0, 3'b000, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R8 stop burst");
                // R8 stop in idle has no effect
                step(1'b0, '0, 3'b000, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R8 stop idle");
                // R9 restart mid burst
                go(9'd16, 3'b011, 1'b1, 8, 3, "R9 first");
                go(9'd250, 3'b010, 1'b0, 4, 4, "R9 restart");
                idle("R9 end");
                // R8 R9 start together with stop: start wins
                go(9'd40, 3'b011, 1'b0, 8, 2, "R9 pre");
                step(1'b1, 9'd77, 3'b001, 1'b0, 1'b1, 1'b1, 9'd77, 1'b0, "R8 start beats stop");
                step(1'b0, '0, 3'b000, 1'b0, 1'b0, 1'b1, 9'd76, 1'b1, "R8 start beats stop b1");
                idle("R8 end");
                // R10 page + interleaved, reserved codes
                go(9'd333, 3'b111, 1'b1, 1, 1, "R10 page il");
                idle("R10 end");
                go(9'd334, 3'b101, 1'b0, 1, 1, "R10 R3 reserved");
                idle("R3 reserved end");
                repeat (3) @(posedge clk);
                done = 1;
            end
            begin
                while (!done && wd < 100000) begin
                    @(posedge clk);
                    wd++;
                end
                if (!done) begin
                    checks++;
                    failures++;
                    $display("FAIL watchdog: got timeout expected completion");
                end
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule